// File: doc/BRIEF.md
# PLL Divider Programming Sequencer

This block holds the two 3-bit divider fields of a clock synthesizer: a feedback multiplier field (MFD) and a post divider field (RFD). It drives them to an analog PLL, which is not part of this project. A write names a target pair. The sequencer moves the PLL to that pair so that the output frequency never overshoots on the way. It first raises the post divider one step above its target, then loads the new multiplier, waits for the PLL to report lock, and only then loads the final post divider.

The block also reports the ratio of system clock to reference clock as a numerator and a power-of-two exponent. The value depends on the clock mode. Normal PLL mode uses the fields. The 1:1 mode reports unity. External clock mode reports one half. A target whose ratio would exceed a configurable ceiling is refused. A write that arrives while a sequence is in flight is dropped.

Top module: `pll_div_seq`

## Requirements
- R1: After synchronous reset the multiplier field is 0, the post divider field is 1, busy, done and error are low, and in normal mode the ratio reads numerator 4 with exponent 1 (twice the reference).
- R2: In normal PLL mode (mode 0, and the reserved mode 3) the ratio outputs show numerator 2·(MFD+2) and exponent RFD. They are registered and follow the fields and the mode one clock later.
- R3: An accepted write raises busy at the next edge. At the edge after that the post divider field becomes the target plus one. At the following edge the multiplier field becomes its target.
- R4: With the new multiplier loaded, the sequencer holds busy and both field values for as long as lock is low. At the first edge where lock is sampled high, it writes the target post divider, drops busy and pulses done for one clock.
- R5: A write from idle whose ratio 2·(MFD+2)/2^RFD exceeds MAX_RATIO (default 8) pulses error for one clock at the next edge. It does not raise busy and leaves both fields unchanged.
- R6: A write made while busy is ignored. It raises no error, and the sequence finishes on the first target.
- R7: In 1:1 mode (mode 1) the ratio reads numerator 1 and exponent 0 whatever the fields are. The fields still accept and store writes.
- R8: In external clock mode (mode 2) the ratio reads numerator 1 and exponent 1.
- R9: When the target post divider is 7, the intermediate post divider value saturates at 7 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | One-clock write strobe for a new target |
| wr_mfd_i | input | 3 | Target multiplier field |
| wr_rfd_i | input | 3 | Target post divider field |
| lock_i | input | 1 | PLL lock status |
| mode_i | input | 2 | Clock mode: 0 PLL, 1 one-to-one, 2 external, 3 treated as PLL |
| mfd_o | output | 3 | Multiplier field driven to the PLL |
| rfd_o | output | 3 | Post divider field driven to the PLL |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-clock pulse when a sequence completes |
| err_o | output | 1 | One-clock pulse when a write is refused |
| ratio_num_o | output | 5 | Ratio numerator |
| ratio_exp_o | output | 3 | Ratio exponent (divide by 2^exp) |

## Verification
The bench watches the intermediate step on every sequence. A design that loaded the multiplier first, or skipped the raised post divider, would show the wrong field values while it waits for lock. Lock is held low for a random number of clocks, so a sequencer that finishes without lock, or a done pulse held longer than one clock, is caught. Targets sit on both sides of the ratio ceiling, including the exact limit, and include a post divider of 7 to catch a wrapping increment. A second write during a wait checks that a design which accepted it would corrupt the fields or raise error. Mode changes check that 1:1 and external modes override the field-derived ratio.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [1:0] {
    MODE_PLL = 2'd0,
    MODE_ONE = 2'd1,
    MODE_EXT = 2'd2,
    MODE_RSV = 2'd3
  } clk_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STEP = 2'd1,
    ST_MFD  = 2'd2,
    ST_WAIT = 2'd3
  } seq_state_e;

endpackage

// File: rtl/pll_req_check.sv
module pll_req_check #(
  parameter int FW        = 3,
  parameter int NUM_W     = FW + 2,
  parameter int MAX_RATIO = 8
) (
  input  logic [FW-1:0] mfd_i,
  input  logic [FW-1:0] rfd_i,
  output logic          ok_o
);
  localparam int SPAN = 1 << FW;

  logic [31:0] lim_tab [SPAN];
  logic [31:0] num;

  // ceiling per post divider setting: MAX_RATIO scaled by 2^rfd
  for (genvar g = 0; g < SPAN; g++) begin : g_lim
    assign lim_tab[g] = 32'(MAX_RATIO) << g;
  end

  always_comb begin
    num  = 32'(2 * (int'(mfd_i) + 2));
    ok_o = (num <= lim_tab[rfd_i]);
  end

endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
  import pll_seq_pkg::*;
#(
  parameter int          FW      = 3,
  parameter logic [FW-1:0] RST_MFD = '0,
  parameter logic [FW-1:0] RST_RFD = FW'(1)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          wr_en_i,
  input  logic [FW-1:0] wr_mfd_i,
  input  logic [FW-1:0] wr_rfd_i,
  input  logic          req_ok_i,
  input  logic          lock_i,
  output logic [FW-1:0] mfd_o,
  output logic [FW-1:0] rfd_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o
);
  localparam logic [FW-1:0] RFD_TOP = '1;

  seq_state_e    state;
  logic [FW-1:0] tgt_mfd;
  logic [FW-1:0] tgt_rfd;
  logic [FW-1:0] step_rfd;

  // one step coarser than the target, held at the top code
  always_comb step_rfd = (tgt_rfd == RFD_TOP) ? RFD_TOP : tgt_rfd + FW'(1);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state   <= ST_IDLE;
      tgt_mfd <= RST_MFD;
      tgt_rfd <= RST_RFD;
      mfd_o   <= RST_MFD;
      rfd_o   <= RST_RFD;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (wr_en_i) begin
            if (req_ok_i) begin
              tgt_mfd <= wr_mfd_i;
              tgt_rfd <= wr_rfd_i;
              busy_o  <= 1'b1;
              state   <= ST_STEP;
            end else begin
              err_o <= 1'b1;
            end
          end
        end
        ST_STEP: begin
          rfd_o <= step_rfd;
          state <= ST_MFD;
        end
        ST_MFD: begin
          mfd_o <= tgt_mfd;
          state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (lock_i) begin
            rfd_o  <= tgt_rfd;
            busy_o <= 1'b0;
            done_o <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_IDLE_FIELDS_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    (!busy_o && !wr_en_i) |=> ($stable(mfd_o) && $stable(rfd_o))); // R6

  AST_WAIT_STEP_VALUES: assert property (@(posedge clk_i) disable iff (rst_i)
    (state == ST_WAIT) |-> (rfd_o >= tgt_rfd && mfd_o == tgt_mfd)); // R3

  AST_WAIT_HOLDS_BUSY: assert property (@(posedge clk_i) disable iff (rst_i)
    (state == ST_WAIT && !lock_i) |=> (busy_o && $stable(rfd_o))); // R4

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |-> (!busy_o && $fell(busy_o))); // R4

  AST_ERR_NO_START: assert property (@(posedge clk_i) disable iff (rst_i)
    err_o |-> (!busy_o && $stable(rfd_o) && $stable(mfd_o))); // R5

  AST_ONE_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0({done_o, err_o})); // R5

endmodule

// File: rtl/pll_ratio_out.sv
module pll_ratio_out
  import pll_seq_pkg::*;
#(
  parameter int            FW      = 3,
  parameter int            NUM_W   = FW + 2,
  parameter logic [FW-1:0] RST_MFD = '0,
  parameter logic [FW-1:0] RST_RFD = FW'(1)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [1:0]       mode_i,
  input  logic [FW-1:0]    mfd_i,
  input  logic [FW-1:0]    rfd_i,
  output logic [NUM_W-1:0] num_o,
  output logic [FW-1:0]    exp_o
);
  logic [NUM_W-1:0] num_nx;
  logic [FW-1:0]    exp_nx;
  logic [FW-1:0]    mfd_sel;
  logic [FW-1:0]    rfd_sel;

  always_comb begin
    mfd_sel = rst_i ? RST_MFD : mfd_i;
    rfd_sel = rst_i ? RST_RFD : rfd_i;
    unique case (clk_mode_e'(mode_i))
      MODE_ONE: begin
        num_nx = NUM_W'(1);
        exp_nx = '0;
      end
      MODE_EXT: begin
        num_nx = NUM_W'(1);
        exp_nx = FW'(1);
      end
      default: begin
        num_nx = NUM_W'(2 * (int'(mfd_sel) + 2));
        exp_nx = rfd_sel;
      end
    endcase
  end

  always_ff @(posedge clk_i) begin
    num_o <= num_nx;
    exp_o <= exp_nx;
  end

  AST_ONE_TO_ONE_UNITY: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(mode_i) == 2'd1) |-> (num_o == NUM_W'(1) && exp_o == '0)); // R7

  AST_EXT_HALF: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(mode_i) == 2'd2) |-> (num_o == NUM_W'(1) && exp_o == FW'(1))); // R8

  AST_PLL_NUM_EVEN: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && ($past(mode_i) == 2'd0 || $past(mode_i) == 2'd3))
      |-> (num_o[0] == 1'b0 && num_o >= NUM_W'(4))); // R2

endmodule

// File: rtl/pll_div_seq.sv
module pll_div_seq #(
  parameter int FW        = 3,
  parameter int MAX_RATIO = 8,
  parameter int RST_MFD   = 0,
  parameter int RST_RFD   = 1,
  localparam int NUM_W    = FW + 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             wr_en_i,
  input  logic [FW-1:0]    wr_mfd_i,
  input  logic [FW-1:0]    wr_rfd_i,
  input  logic             lock_i,
  input  logic [1:0]       mode_i,
  output logic [FW-1:0]    mfd_o,
  output logic [FW-1:0]    rfd_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [NUM_W-1:0] ratio_num_o,
  output logic [FW-1:0]    ratio_exp_o
);
  localparam logic [FW-1:0] R_MFD = FW'(RST_MFD);
  localparam logic [FW-1:0] R_RFD = FW'(RST_RFD);

  logic req_ok;

  pll_req_check #(
    .FW(FW), .NUM_W(NUM_W), .MAX_RATIO(MAX_RATIO)
  ) chk_i (
    .mfd_i (wr_mfd_i),
    .rfd_i (wr_rfd_i),
    .ok_o  (req_ok)
  );

  pll_seq_fsm #(
    .FW(FW), .RST_MFD(R_MFD), .RST_RFD(R_RFD)
  ) fsm_i (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .wr_en_i  (wr_en_i),
    .wr_mfd_i (wr_mfd_i),
    .wr_rfd_i (wr_rfd_i),
    .req_ok_i (req_ok),
    .lock_i   (lock_i),
    .mfd_o    (mfd_o),
    .rfd_o    (rfd_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .err_o    (err_o)
  );

  pll_ratio_out #(
    .FW(FW), .NUM_W(NUM_W), .RST_MFD(R_MFD), .RST_RFD(R_RFD)
  ) ratio_i (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .mode_i (mode_i),
    .mfd_i  (mfd_o),
    .rfd_i  (rfd_o),
    .num_o  (ratio_num_o),
    .exp_o  (ratio_exp_o)
  );

  AST_REFUSE_FLAG: assert property (@(posedge clk_i) disable iff (rst_i)
    (!busy_o && wr_en_i && !req_ok) |=> err_o); // R5

  AST_BUSY_WRITE_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_o && wr_en_i) |=> !err_o); // R6

endmodule

// File: tb/pll_div_seq_tb_top.sv
`timescale 1ns/1ps
module pll_div_seq_tb_top;
  localparam int MAXR = 8;

  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en;
  logic [2:0] wr_mfd;
  logic [2:0] wr_rfd;
  logic       lock;
  logic [1:0] mode;
  logic [2:0] mfd_o, rfd_o;
  logic       busy_o, done_o, err_o;
  logic [4:0] num_o;
  logic [2:0] exp_o;

  int compared   = 0;
  int mismatched = 0;
  int cur_mfd    = 0;
  int cur_rfd    = 1;

  always #2 clk = ~clk;

  pll_div_seq dut_i (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_mfd_i(wr_mfd),
    .wr_rfd_i(wr_rfd), .lock_i(lock), .mode_i(mode), .mfd_o(mfd_o),
    .rfd_o(rfd_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .ratio_num_o(num_o), .ratio_exp_o(exp_o)
  );

  function automatic int e_num(int md, int m);
    if (md == 1 || md == 2) return 1;
    return 2 * (m + 2);
  endfunction

  function automatic int e_exp(int md, int r);
    if (md == 1) return 0;
    if (md == 2) return 1;
    return r;
  endfunction

  function automatic bit e_ok(int m, int r);
    return (2 * (m + 2)) <= (MAXR << r);
  endfunction

  function automatic int e_step(int r);
    return (r == 7) ? 7 : r + 1;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  task automatic check_ratio(string req);
    chk(req, "ratio_num", int'(num_o), e_num(int'(mode), cur_mfd));
    chk(req, "ratio_exp", int'(exp_o), e_exp(int'(mode), cur_rfd));
  endtask

  // full write; on entry and exit the bench sits just after a falling edge
  task automatic run_write(int m, int r, int ldly, bit intrude);
    wr_en  = 1'b1;
    wr_mfd = 3'(m);
    wr_rfd = 3'(r);
    @(negedge clk);
    wr_en = 1'b0;
    if (!e_ok(m, r)) begin
      chk("R5", "err", int'(err_o), 1);
      chk("R5", "busy", int'(busy_o), 0);
      chk("R5", "mfd", int'(mfd_o), cur_mfd);
      chk("R5", "rfd", int'(rfd_o), cur_rfd);
      @(negedge clk);
      chk("R5", "err pulse", int'(err_o), 0);
      return;
    end
    chk("R3", "busy rise", int'(busy_o), 1);
    chk("R5", "no err", int'(err_o), 0);
    @(negedge clk);
    chk(r == 7 ? "R9" : "R3", "step rfd", int'(rfd_o), e_step(r));
    chk("R3", "mfd still old", int'(mfd_o), cur_mfd);
    @(negedge clk);
    chk("R3", "mfd loaded", int'(mfd_o), m);
    for (int i = 0; i < ldly; i++) begin
      if (intrude && i == 0) begin
        wr_en  = 1'b1;
        wr_mfd = 3'(m ^ 1);
        wr_rfd = 3'(r ^ 2);
      end
      @(negedge clk);
      wr_en = 1'b0;
      chk("R4", "busy wait", int'(busy_o), 1);
      chk("R4", "rfd wait", int'(rfd_o), e_step(r));
      chk("R4", "done low", int'(done_o), 0);
      if (intrude) chk("R6", "no err busy", int'(err_o), 0);
    end
    lock = 1'b1;
    @(negedge clk);
    lock = 1'b0;
    chk("R4", "final rfd", int'(rfd_o), r);
    chk(intrude ? "R6" : "R4", "final mfd", int'(mfd_o), m);
    chk("R4", "busy fall", int'(busy_o), 0);
    chk("R4", "done", int'(done_o), 1);
    cur_mfd = m;
    cur_rfd = r;
    @(negedge clk);
    chk("R4", "done pulse", int'(done_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd5281));
    rst = 1'b1; wr_en = 1'b0; wr_mfd = '0; wr_rfd = '0; lock = 1'b0; mode = 2'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "mfd", int'(mfd_o), 0);
    chk("R1", "rfd", int'(rfd_o), 1);
    chk("R1", "busy", int'(busy_o), 0);
    chk("R1", "done", int'(done_o), 0);
    chk("R1", "err", int'(err_o), 0);
    chk("R1", "num", int'(num_o), 4);
    chk("R1", "exp", int'(exp_o), 1);

    // directed corners
    run_write(2, 0, 3, 1'b0);   // exact ceiling, accepted (R5 boundary)
    @(negedge clk); check_ratio("R2");
    run_write(3, 0, 2, 1'b0);   // ratio 10 > 8, refused
    check_ratio("R5");
    run_write(7, 7, 0, 1'b0);   // saturating step (R9)
    @(negedge clk); check_ratio("R2");
    run_write(5, 2, 4, 1'b1);   // write while busy (R6)
    @(negedge clk); check_ratio("R6");
    mode = 2'd1;
    @(negedge clk); @(negedge clk);
    check_ratio("R7");
    run_write(1, 3, 1, 1'b0);
    @(negedge clk); check_ratio("R7");
    mode = 2'd2;
    @(negedge clk); @(negedge clk);
    check_ratio("R8");
    mode = 2'd3;
    @(negedge clk); @(negedge clk);
    check_ratio("R2");

    // random mix
    for (int it = 0; it < 60; it++) begin
      int m  = int'($urandom_range(0, 7));
      int r  = int'($urandom_range(0, 7));
      int d  = int'($urandom_range(0, 5));
      bit ib = ($urandom_range(0, 3) == 0) && d > 0;
      mode = 2'($urandom_range(0, 3));
      @(negedge clk);
      run_write(m, r, d, ib);
      @(negedge clk);
      check_ratio(mode == 2'd1 ? "R7" : (mode == 2'd2 ? "R8" : "R2"));
    end
    summary();
  end

endmodule